// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block arbitrates eight interrupt request lines and hands the winning line's 8-bit vector to a processor through a one-cycle acknowledge strobe. Software programs it through a byte-wide port with two addresses. The command address (`addrSel`=0) takes the start of initialization, end-of-interrupt commands and the read-select command. The data address (`addrSel`=1) takes the remaining initialization words and, once initialization is complete, the interrupt mask.

Priority is fixed, with line 0 highest. A line raises `intOut` only if it is requesting, unmasked, and higher in priority than every line already in service. Each line senses either a level or a rising edge. In-service bits are cleared by a specific or non-specific end-of-interrupt command, or automatically after the acknowledge.

Two instances can be chained. On a master, the lines marked in its cascade map have a slave attached, and the master announces the line number on `casOut` instead of supplying a vector. A slave, selected by `isSlave`, answers an acknowledge only when `casIn` matches its identity. If no request is present when the acknowledge arrives, the block returns a spurious vector for line 7.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the request and in-service registers are 0, the mask is 0xFF, `intOut` is 0, and a read at the command address returns the request register.
- R2: A command-address write with bit 4 set starts initialization and clears the in-service register, the mask (to 0x00) and the edge latches, and selects the request register for reads. Its bit 1 set means single (no third word), bit 0 set means a fourth word follows, and bit 3 set makes every line level-sensed. The following data-address writes are taken in order as vector base, cascade word (skipped when single) and mode word (only when bit 0 was set). Only after those does a data write go to the mask.
- R3: On an acknowledge, the vector `base + n` for the winning line n is on `vecOut`, with `vecValid` high, in the cycle after the `ackIn` cycle. In that same `ackIn` cycle in-service bit n is set.
- R4: Line 0 has the highest priority. A request is presented only if its index is below that of every set in-service bit.
- R5: Outside initialization, a data-address write loads the mask (1 = masked) and a data-address read returns it. A masked line neither raises `intOut` nor wins an acknowledge.
- R6: Command write 0x0A selects the request register and 0x0B selects the in-service register for command-address reads. The choice holds across other writes until it is changed.
- R7: Command write 0x60+n clears in-service bit n alone. Command write 0x20 clears the lowest-indexed set in-service bit.
- R8: When mode-word bit 1 is set, an in-service bit set by an acknowledge clears at the end of the following cycle, with no end-of-interrupt command.
- R9: An acknowledge with no presented request returns `base + 7` and sets no in-service bit, even when line 7 is masked.
- R10: With `trigMode[n]`=1 or level-all set, request n follows the input. Otherwise request n latches on a rising edge, is dropped when the input goes low, and is cleared by its own acknowledge.
- R11: On a master (`isSlave`=0), if the winner n has its cascade-word bit set, then during `ackIn` `casEn`=1 and `casOut`=n, no vector is given, and in-service bit n is set.
- R12: A slave (`isSlave`=1) takes its identity from cascade-word bits 2:0. It answers `ackIn` only when `casIn` equals that identity; otherwise `vecValid` stays 0 and nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addrSel | input | 1 | 0 = command address, 1 = data address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| isSlave | input | 1 | 1 = act as slave in a cascade |
| irqIn | input | 8 | Interrupt request lines |
| trigMode | input | 8 | Per-line sensing, 1 = level |
| intOut | output | 1 | Interrupt pending to processor or master |
| ackIn | input | 1 | One-cycle acknowledge strobe |
| vecOut | output | 8 | Acknowledged vector |
| vecValid | output | 1 | `vecOut` valid this cycle |
| casIn | input | 3 | Cascade line number from the master |
| casOut | output | 3 | Cascade line number announced to slaves |
| casEn | output | 1 | `casOut` valid |

## Verification
Priority is exercised with two simultaneous edge requests. This shows that the lower index wins and that an in-service line blocks the lower-priority one until its end-of-interrupt. A masked high-priority line with an unmasked lower one separates masking from priority. A request held high through its acknowledge, first edge-sensed and then level-sensed, separates the two sensing modes. A level request withdrawn before the acknowledge, with line 7 masked, checks the spurious path. The cascade is covered from both sides: a master announcing line 2, and a slave given first a foreign identity and then its own.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;
  localparam int IN_N  = 8;
  localparam int IDX_W = $clog2(IN_N);

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} initSt_t;

  typedef struct packed {
    logic             initClr;
    logic             maskLd;
    logic             specEoi;
    logic             anyEoi;
    logic [IDX_W-1:0] eoiLvl;
    logic [IN_N-1:0]  wdat;
  } ctlStrb_t;

  typedef struct packed {
    logic [7:0]      base;
    logic [IN_N-1:0] cascMap;
    logic            aeoi;
    logic            lvlAll;
  } cfg_t;
endpackage

// File: rtl/cascade_irq_ctl.sv
module cascade_irq_ctl
  import cascade_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            addrSel,
  input  logic [7:0]      wrData,
  input  logic [IN_N-1:0] irrVec,
  input  logic [IN_N-1:0] isrVec,
  input  logic [IN_N-1:0] imrVec,
  output logic [7:0]      rdData,
  output ctlStrb_t        strb,
  output cfg_t            cfg
);
  initSt_t state;
  logic single, wantMode, readIsr;
  logic cmdWr, datWr;

  assign cmdWr = wrEn && !addrSel;
  assign datWr = wrEn && addrSel;

  always_comb begin
    strb = '0;
    strb.wdat   = wrData;
    strb.eoiLvl = wrData[IDX_W-1:0];
    if (cmdWr && wrData[4]) begin
      strb.initClr = 1'b1;
    end else if (cmdWr && !wrData[3] && state == ST_RUN) begin
      strb.specEoi = (wrData[7:5] == 3'b011);
      strb.anyEoi  = (wrData[7:5] == 3'b001);
    end else if (datWr && state == ST_RUN) begin
      strb.maskLd = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_RUN;
      single   <= 1'b0;
      wantMode <= 1'b0;
      readIsr  <= 1'b0;
      cfg      <= '0;
    end else if (cmdWr && wrData[4]) begin
      state      <= ST_BASE;
      single     <= wrData[1];
      wantMode   <= wrData[0];
      cfg.lvlAll <= wrData[3];
      cfg.aeoi   <= 1'b0;
      readIsr    <= 1'b0;
    end else if (cmdWr && wrData[3] && wrData[1] && state == ST_RUN) begin
      readIsr <= wrData[0];
    end else if (datWr) begin
      case (state)
        ST_BASE: begin
          cfg.base <= wrData;
          state    <= !single ? ST_CASC : (wantMode ? ST_MODE : ST_RUN);
        end
        ST_CASC: begin
          cfg.cascMap <= wrData;
          state       <= wantMode ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          cfg.aeoi <= wrData[1];
          state    <= ST_RUN;
        end
        default: ;
      endcase
    end
  end

  assign rdData = addrSel ? imrVec : (readIsr ? isrVec : irrVec);

  // R2: an initialization start always expects the vector base next
  a_r2_init_entry: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[4]) |=> (state == ST_BASE));
endmodule

// File: rtl/cascade_irq_dp.sv
module cascade_irq_dp
  import cascade_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  cfg_t             cfg,
  input  logic             isSlave,
  input  logic [IN_N-1:0]  irqIn,
  input  logic [IN_N-1:0]  trigMode,
  input  logic             ackIn,
  input  logic [IDX_W-1:0] casIn,
  output logic [IN_N-1:0]  irrVec,
  output logic [IN_N-1:0]  isrVec,
  output logic [IN_N-1:0]  imrVec,
  output logic             intOut,
  output logic [7:0]       vecOut,
  output logic             vecValid,
  output logic [IDX_W-1:0] casOut,
  output logic             casEn
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IN_N - 1);

  logic [IN_N-1:0]  imr, isr, edgeLat, prevIrq, ackBit, isrNxt, latNxt;
  logic [IN_N-1:0]  levelMode, pend, allowed, winBit;
  logic [IDX_W-1:0] winIdx, lowIsr;
  logic             hasReq, lowHit, ackPend, respond, ackTake, toSlave, blk;

  assign levelMode = trigMode | {IN_N{cfg.lvlAll}};
  assign irrVec    = (levelMode & irqIn) | (~levelMode & edgeLat & irqIn);
  assign pend      = irrVec & ~imr;

  always_comb begin
    blk     = 1'b0;
    allowed = '0;
    hasReq  = 1'b0;
    winIdx  = '0;
    lowHit  = 1'b0;
    lowIsr  = '0;
    for (int i = 0; i < IN_N; i++) begin
      if (isr[i]) blk = 1'b1;
      allowed[i] = pend[i] && !blk;
      if (allowed[i] && !hasReq) begin
        hasReq = 1'b1;
        winIdx = IDX_W'(i);
      end
      if (isr[i] && !lowHit) begin
        lowHit = 1'b1;
        lowIsr = IDX_W'(i);
      end
    end
  end

  assign winBit  = IN_N'(1) << winIdx;
  assign respond = isSlave ? (casIn == cfg.cascMap[IDX_W-1:0]) : 1'b1;
  assign ackTake = ackIn && respond;
  assign toSlave = !isSlave && hasReq && cfg.cascMap[winIdx];
  assign casEn   = ackIn && toSlave;
  assign casOut  = casEn ? winIdx : '0;
  assign intOut  = hasReq;

  always_comb begin
    latNxt = (edgeLat | (irqIn & ~prevIrq)) & irqIn;
    isrNxt = isr;
    if (ackPend && cfg.aeoi)  isrNxt = isrNxt & ~ackBit;
    if (strb.specEoi)         isrNxt = isrNxt & ~(IN_N'(1) << strb.eoiLvl);
    if (strb.anyEoi && lowHit) isrNxt = isrNxt & ~(IN_N'(1) << lowIsr);
    if (ackTake && hasReq) begin
      isrNxt = isrNxt | winBit;
      latNxt = latNxt & ~winBit;
    end
    if (strb.initClr) begin
      isrNxt = '0;
      latNxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imr      <= '1;
      isr      <= '0;
      edgeLat  <= '0;
      prevIrq  <= '0;
      ackBit   <= '0;
      ackPend  <= 1'b0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      prevIrq  <= irqIn;
      edgeLat  <= latNxt;
      isr      <= isrNxt;
      vecValid <= 1'b0;
      ackPend  <= 1'b0;
      if (strb.initClr)     imr <= '0;
      else if (strb.maskLd) imr <= strb.wdat;
      if (ackTake) begin
        vecValid <= !toSlave;
        vecOut   <= cfg.base + {{(8-IDX_W){1'b0}}, (hasReq ? winIdx : LAST_IDX)};
        ackBit   <= hasReq ? winBit : '0;
        ackPend  <= hasReq;
      end
    end
  end

  assign isrVec = isr;
  assign imrVec = imr;

  // R4: an acknowledge adds at most one in-service bit per cycle
  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $onehot0(isr & ~$past(isr)));
  // R5: a line masked in the previous cycle never becomes in service
  a_r5_mask_honoured: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((isr & ~$past(isr) & $past(imr)) == '0));
  // R9: a spurious acknowledge grants nothing
  a_r9_spurious_clean: assert property (@(posedge clk) disable iff (!rstN)
    (ackTake && !hasReq) |=> ((isr & ~$past(isr)) == '0));
  // R7: a specific end-of-interrupt clears its bit
  a_r7_spec_eoi: assert property (@(posedge clk) disable iff (!rstN)
    (strb.specEoi && !(ackTake && hasReq)) |=> !isr[$past(strb.eoiLvl)]);
  // R8: automatic end-of-interrupt clears the granted bit one cycle later
  a_r8_auto_eoi: assert property (@(posedge clk) disable iff (!rstN)
    (ackPend && cfg.aeoi) |=> ((isr & $past(ackBit)) == '0));
  // R11: only a master announces a cascade line
  a_r11_master_only: assert property (@(posedge clk) disable iff (!rstN)
    casEn |-> !isSlave);
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cascade_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       addrSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       isSlave,
  input  logic [7:0] irqIn,
  input  logic [7:0] trigMode,
  output logic       intOut,
  input  logic       ackIn,
  output logic [7:0] vecOut,
  output logic       vecValid,
  input  logic [2:0] casIn,
  output logic [2:0] casOut,
  output logic       casEn
);
  ctlStrb_t        strb;
  cfg_t            cfg;
  logic [IN_N-1:0] irrVec, isrVec, imrVec;

  cascade_irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addrSel(addrSel), .wrData(wrData),
    .irrVec(irrVec), .isrVec(isrVec), .imrVec(imrVec), .rdData(rdData),
    .strb(strb), .cfg(cfg)
  );

  cascade_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .isSlave(isSlave),
    .irqIn(irqIn), .trigMode(trigMode), .ackIn(ackIn), .casIn(casIn),
    .irrVec(irrVec), .isrVec(isrVec), .imrVec(imrVec), .intOut(intOut),
    .vecOut(vecOut), .vecValid(vecValid), .casOut(casOut), .casEn(casEn)
  );
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, addrSel = 1'b0;
  logic [7:0] wrData = '0, irqIn = '0, trigMode = '0;
  logic isSlave = 1'b0, ackIn = 1'b0;
  logic [2:0] casIn = '0;
  logic [7:0] rdData, vecOut;
  logic intOut, vecValid, casEn;
  logic [2:0] casOut;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic ackCe, ackVv;
  logic [2:0] ackCo;
  logic [7:0] ackVec;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addrSel(addrSel), .wrData(wrData),
    .rdData(rdData), .isSlave(isSlave), .irqIn(irqIn), .trigMode(trigMode),
    .intOut(intOut), .ackIn(ackIn), .vecOut(vecOut), .vecValid(vecValid),
    .casIn(casIn), .casOut(casOut), .casEn(casEn)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addrSel = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; #1;
  endtask

  task automatic rd(logic a, string tag, logic [7:0] exp);
    addrSel = a; #1;
    chk(tag, rdData, exp);
  endtask

  task automatic ack(logic [2:0] c);
    @(negedge clk);
    ackIn = 1'b1; casIn = c; #1;
    ackCe = casEn; ackCo = casOut;
    @(negedge clk);
    ackIn = 1'b0; #1;
    ackVv = vecValid; ackVec = vecOut;
  endtask

  task automatic t_reset();
    rd(1'b0, "R1 request reg after reset", 8'h00);
    rd(1'b1, "R1 mask after reset", 8'hFF);
    chk("R1 intOut after reset", {7'b0, intOut}, 8'h00);
  endtask

  task automatic t_init();
    wr(1'b0, 8'h11); wr(1'b1, 8'h30); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, "R2 init clears mask", 8'h00);
  endtask

  task automatic t_prio();
    irqIn[3] = 1'b1; irqIn[5] = 1'b1; tick(); tick();
    chk("R4 intOut with two requests", {7'b0, intOut}, 8'h01);
    wr(1'b0, 8'h0A);
    rd(1'b0, "R6 request reg", 8'h28);
    ack(3'd0);
    chk("R3 vecValid", {7'b0, ackVv}, 8'h01);
    chk("R3 R4 vector line 3", ackVec, 8'h33);
    wr(1'b0, 8'h0B);
    rd(1'b0, "R6 in-service reg", 8'h08);
    chk("R4 line 5 blocked by in-service 3", {7'b0, intOut}, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b0, "R6 select persists", 8'h08);
    wr(1'b0, 8'h63);
    rd(1'b0, "R7 specific eoi 3", 8'h00);
    chk("R4 line 5 presented after eoi", {7'b0, intOut}, 8'h01);
    ack(3'd0);
    chk("R3 vector line 5", ackVec, 8'h35);
    wr(1'b0, 8'h61);
    rd(1'b0, "R7 specific eoi other bit", 8'h20);
    wr(1'b0, 8'h20);
    rd(1'b0, "R7 nonspecific eoi", 8'h00);
    irqIn = '0; tick();
  endtask

  task automatic t_mask();
    wr(1'b1, 8'h02);
    rd(1'b1, "R5 mask readback", 8'h02);
    irqIn[1] = 1'b1; tick(); tick();
    chk("R5 masked line no intOut", {7'b0, intOut}, 8'h00);
    irqIn[4] = 1'b1; tick(); tick();
    ack(3'd0);
    chk("R5 masked line skipped", ackVec, 8'h34);
    wr(1'b0, 8'h64);
    irqIn = '0; tick();
    wr(1'b1, 8'h00);
  endtask

  task automatic t_sense();
    wr(1'b0, 8'h0A);
    irqIn[0] = 1'b1; tick();
    rd(1'b0, "R10 edge latched", 8'h01);
    ack(3'd0);
    chk("R10 edge vector", ackVec, 8'h30);
    rd(1'b0, "R10 edge cleared by ack while high", 8'h00);
    wr(1'b0, 8'h60);
    chk("R10 edge no re-request", {7'b0, intOut}, 8'h00);
    irqIn[0] = 1'b0; tick();
    trigMode[0] = 1'b1; irqIn[0] = 1'b1; #1;
    rd(1'b0, "R10 level follows input", 8'h01);
    ack(3'd0);
    rd(1'b0, "R10 level held after ack", 8'h01);
    wr(1'b0, 8'h60);
    irqIn[0] = 1'b0; #1;
    rd(1'b0, "R10 level drops with input", 8'h00);
    trigMode = '0; tick();
  endtask

  task automatic t_spurious();
    wr(1'b1, 8'h80);
    trigMode[6] = 1'b1; irqIn[6] = 1'b1; #1;
    chk("R9 level request pending", {7'b0, intOut}, 8'h01);
    tick();
    irqIn[6] = 1'b0; #1;
    ack(3'd0);
    chk("R9 spurious vecValid", {7'b0, ackVv}, 8'h01);
    chk("R9 spurious vector with line 7 masked", ackVec, 8'h37);
    wr(1'b0, 8'h0B);
    rd(1'b0, "R9 no in-service bit", 8'h00);
    wr(1'b1, 8'h00);
    trigMode = '0;
  endtask

  task automatic t_cascMaster();
    irqIn[2] = 1'b1; tick();
    ack(3'd0);
    chk("R11 casEn", {7'b0, ackCe}, 8'h01);
    chk("R11 casOut", {5'b0, ackCo}, 8'h02);
    chk("R11 no vector from master", {7'b0, ackVv}, 8'h00);
    rd(1'b0, "R11 cascade line in service", 8'h04);
    wr(1'b0, 8'h62);
    irqIn = '0; tick();
  endtask

  task automatic t_aeoi();
    wr(1'b0, 8'h11); wr(1'b1, 8'h30); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    wr(1'b0, 8'h0B);
    irqIn[1] = 1'b1; tick();
    ack(3'd0);
    chk("R8 vector", ackVec, 8'h31);
    rd(1'b0, "R8 in service during vector cycle", 8'h02);
    tick();
    rd(1'b0, "R8 auto cleared", 8'h00);
    irqIn = '0; tick();
  endtask

  task automatic t_slave();
    isSlave = 1'b1;
    wr(1'b0, 8'h11); wr(1'b1, 8'h38); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    wr(1'b0, 8'h0B);
    irqIn[5] = 1'b1; tick();
    ack(3'd3);
    chk("R12 foreign id no vector", {7'b0, ackVv}, 8'h00);
    rd(1'b0, "R12 foreign id no in-service", 8'h00);
    chk("R12 slave never drives casEn", {7'b0, ackCe}, 8'h00);
    ack(3'd2);
    chk("R12 own id vecValid", {7'b0, ackVv}, 8'h01);
    chk("R12 own id vector", ackVec, 8'h3D);
    rd(1'b0, "R12 own id in service", 8'h20);
    wr(1'b0, 8'h65);
    irqIn = '0; isSlave = 1'b0; tick();
  endtask

  task automatic t_shortInit();
    wr(1'b0, 8'h1A); wr(1'b1, 8'h40); wr(1'b1, 8'h01);
    rd(1'b1, "R2 single no-mode init, next write is mask", 8'h01);
    irqIn[6] = 1'b1; #1;
    chk("R2 level-all bit makes line level", {7'b0, intOut}, 8'h01);
    ack(3'd0);
    chk("R2 new base vector", ackVec, 8'h46);
    irqIn = '0; tick();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1; #1;
    t_reset();
    t_init();
    t_prio();
    t_mask();
    t_sense();
    t_spurious();
    t_cascMaster();
    t_aeoi();
    t_slave();
    t_shortInit();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule